// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects a vector of interrupt sources and decides when the processor must branch to a service routine. It also supplies the branch target. Every source has a latched flag, a per-source enable and a priority bit. The low-numbered sources form the core group. The rest form the peripheral group. Two global enable bits are held inside the block. The processor's return-from-interrupt strobe and software writes update them.

With `prio_mode_i` low, the block runs in compatibility mode. Global bit 1 gates every source, and global bit 0 additionally gates the peripheral group. All branches go to one vector. With `prio_mode_i` high, the block runs in priority mode. Bit 1 is the high-level enable and bit 0 is the low-level enable. A high request may preempt a low service that is already running.

The service level is tracked by a four-state machine:

- **ST_IDLE**: no service is running.
- **ST_LOW**: a low-level service is running.
- **ST_HIGH**: a high-level service is running, or any service in compatibility mode.
- **ST_NEST**: a high service is running that preempted a low one.

The transitions are:

- **TAKE_HI**: ST_IDLE to ST_HIGH.
- **TAKE_LO**: ST_IDLE to ST_LOW.
- **PREEMPT**: ST_LOW to ST_NEST.
- **RET**: ST_LOW to ST_IDLE, ST_HIGH to ST_IDLE, or ST_NEST to ST_LOW.

Top module: `irq_ctrl_top`

## Requirements
- R1: A source flag (`flags_o[i]`) sets on a rising edge of `src_evt_i[i]`, whatever its enable and the global enables are. It stays set until it is cleared.
- R2: While `flag_clr_i` is high, every flag selected in `flag_clr_mask_i` clears on the next edge. A flag whose event edge is detected in that same cycle stays set.
- R3: In compatibility mode (`prio_mode_i`=0), priority bits are ignored and every branch uses vector 0x0008.
- R4: In compatibility mode, a source can be taken only with `glb_en_o[1]`=1. A peripheral source (index >= N_CORE) also needs `glb_en_o[0]`=1.
- R5: In priority mode, a source with priority bit 1 needs `glb_en_o[1]`. A source with priority bit 0 needs both `glb_en_o[1]` and `glb_en_o[0]`.
- R6: In priority mode, a high branch uses vector 0x0008 and a low branch uses 0x0018. If both are pending together, the high one is taken first.
- R7: Each take raises `irq_req_o` for exactly one cycle. In the same cycle, `svc_level_o` is updated (0 idle, 1 low, 2 high). A high take, or any take in compatibility mode, clears `glb_en_o[1]`. A low take clears `glb_en_o[0]`.
- R8: A high request preempts a running low service. A low request is never taken while `svc_level_o`=2.
- R9: `reti_i` leaves the current level and sets the enable of that level: bit 1 when leaving high, bit 0 when leaving low. No take is made in the cycle that `reti_i` is high.
- R10: With SYNC_STAGES=2, `irq_req_o` rises on the fourth rising edge after an event is applied. It is still low after the third edge.
- R11: Returning from a high service that preempted a low one resumes level 1, with `glb_en_o[0]` still cleared.
- R12: After reset, the flags, both global enables, `irq_req_o`, `irq_vec_o` and `svc_level_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt_i | input | N_CORE+N_PERIPH | Raw source events, synchronised internally |
| src_en_i | input | N_CORE+N_PERIPH | Per-source enables |
| src_pri_i | input | N_CORE+N_PERIPH | Per-source priority (1 = high) |
| prio_mode_i | input | 1 | 0 = compatibility mode, 1 = priority mode |
| glb_we_i | input | 1 | Software write strobe for the global enables |
| glb_wdata_i | input | 2 | Global enable write data: bit 1 high/global, bit 0 low/peripheral |
| flag_clr_i | input | 1 | Software flag-clear strobe |
| flag_clr_mask_i | input | N_CORE+N_PERIPH | Flags to clear |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_req_o | output | 1 | One-cycle branch request |
| irq_vec_o | output | VEC_W | Vector of the latest branch |
| svc_level_o | output | 2 | Current service level |
| glb_en_o | output | 2 | Global enables {high/global, low/peripheral} |
| flags_o | output | N_CORE+N_PERIPH | Latched source flags |

## Verification
After an event, the flag is due at the third rising edge and the branch request at the fourth. These edges are counted from the negative edge on which the event is driven. A global-enable write or a return strobe changes `glb_en_o` and `svc_level_o` at the next edge. A take of a flag that is already pending follows one edge after that.

The bench drives every stimulus on a falling edge and samples on falling edges. Each check therefore sits at an exact edge count. The bench checks that `irq_req_o` is low one edge before it is due, and high on the edge where it is due. Cases where a request is blocked are checked over several edges, and the pending flag is then released by a later enable write.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Service-level stack encoded as machine states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_NEST = 2'd3
    } lvl_state_t;

    // Action chosen for the current cycle
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_TAKE_HI = 2'd1,
        ACT_TAKE_LO = 2'd2,
        ACT_RETURN  = 2'd3
    } lvl_act_t;

    localparam logic [1:0] LVL_IDLE = 2'd0;
    localparam logic [1:0] LVL_LOW  = 2'd1;
    localparam logic [1:0] LVL_HIGH = 2'd2;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int unsigned N_SRC       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             clr_i,
    input  logic [N_SRC-1:0] clr_mask_i,
    output logic [N_SRC-1:0] flag_o
);

    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic [CHAIN_W-1:0] chain_q;
        logic               rise;
        logic               flag_q;

        // Synchroniser plus one history stage for edge detection
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[CHAIN_W-2:0], evt_i[g]};
        end

        assign rise = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];

        // A detected edge outranks a software clear in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       flag_q <= 1'b0;
            else if (rise)                    flag_q <= 1'b1;
            else if (clr_i && clr_mask_i[g])  flag_q <= 1'b0;
        end

        assign flag_o[g] = flag_q;
    end

endmodule

// File: rtl/irq_qualify.sv
module irq_qualify #(
    parameter int unsigned N_CORE   = 2,
    parameter int unsigned N_PERIPH = 2
) (
    input  logic [N_CORE+N_PERIPH-1:0] flag_i,
    input  logic [N_CORE+N_PERIPH-1:0] en_i,
    input  logic [N_CORE+N_PERIPH-1:0] pri_i,
    input  logic                       prio_mode_i,
    input  logic                       glb_hi_i,
    input  logic                       glb_lo_i,
    output logic                       want_hi_o,
    output logic                       want_lo_o
);

    localparam int unsigned N_SRC = N_CORE + N_PERIPH;

    logic [N_SRC-1:0] is_periph;
    logic [N_SRC-1:0] armed;
    logic [N_SRC-1:0] compat_pass;
    logic             compat_any;
    logic             prio_hi;
    logic             prio_lo;

    for (genvar g = 0; g < N_SRC; g++) begin : g_grp
        assign is_periph[g] = (g >= N_CORE);
    end

    assign armed = flag_i & en_i;

    // Compatibility: peripheral sources additionally need the low bit
    assign compat_pass = armed & (~is_periph | {N_SRC{glb_lo_i}});
    assign compat_any  = glb_hi_i & (|compat_pass);

    // Priority mode: the high bit gates both levels
    assign prio_hi = glb_hi_i & (|(armed & pri_i));
    assign prio_lo = glb_hi_i & glb_lo_i & (|(armed & ~pri_i));

    assign want_hi_o = prio_mode_i ? prio_hi : compat_any;
    assign want_lo_o = prio_mode_i & prio_lo;

endmodule

// File: rtl/irq_level_fsm.sv
module irq_level_fsm
    import irq_pkg::*;
#(
    parameter int unsigned      VEC_W  = 16,
    parameter logic [VEC_W-1:0] HI_VEC = VEC_W'(8),
    parameter logic [VEC_W-1:0] LO_VEC = VEC_W'(24)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prio_mode_i,
    input  logic             want_hi_i,
    input  logic             want_lo_i,
    input  logic             reti_i,
    input  logic             glb_we_i,
    input  logic [1:0]       glb_wdata_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [1:0]       level_o,
    output logic [1:0]       glb_en_o
);

    lvl_state_t state_q, state_d;
    lvl_act_t   act;
    logic       req_q;
    logic [VEC_W-1:0] vec_q;
    logic       en_hi_q, en_lo_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: RET has precedence, then TAKE_HI / PREEMPT, then TAKE_LO
    always_comb begin
        act     = ACT_NONE;
        state_d = state_q;
        if (reti_i) begin
            unique case (state_q)
                ST_IDLE: ;
                ST_LOW:  begin act = ACT_RETURN; state_d = ST_IDLE; end
                ST_HIGH: begin act = ACT_RETURN; state_d = ST_IDLE; end
                ST_NEST: begin act = ACT_RETURN; state_d = ST_LOW;  end
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (want_hi_i) begin
                        act     = ACT_TAKE_HI;
                        state_d = ST_HIGH;
                    end else if (want_lo_i) begin
                        act     = ACT_TAKE_LO;
                        state_d = ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (prio_mode_i && want_hi_i) begin
                        act     = ACT_TAKE_HI;
                        state_d = ST_NEST;
                    end
                end
                ST_HIGH: ;
                ST_NEST: ;
            endcase
        end
    end

    // Registered outputs: request pulse, vector, global enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            vec_q   <= '0;
            en_hi_q <= 1'b0;
            en_lo_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (glb_we_i) begin
                en_hi_q <= glb_wdata_i[1];
                en_lo_q <= glb_wdata_i[0];
            end
            unique case (act)
                ACT_NONE: ;
                ACT_TAKE_HI: begin
                    req_q   <= 1'b1;
                    vec_q   <= HI_VEC;
                    en_hi_q <= 1'b0;
                end
                ACT_TAKE_LO: begin
                    req_q   <= 1'b1;
                    vec_q   <= LO_VEC;
                    en_lo_q <= 1'b0;
                end
                ACT_RETURN: begin
                    if (state_q == ST_LOW) en_lo_q <= 1'b1;
                    else                   en_hi_q <= 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: level_o = LVL_IDLE;
            ST_LOW:  level_o = LVL_LOW;
            ST_HIGH: level_o = LVL_HIGH;
            ST_NEST: level_o = LVL_HIGH;
        endcase
    end

    assign req_o    = req_q;
    assign vec_o    = vec_q;
    assign glb_en_o = {en_hi_q, en_lo_q};

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
    parameter int unsigned      N_CORE      = 2,
    parameter int unsigned      N_PERIPH    = 2,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter int unsigned      VEC_W       = 16,
    parameter logic [VEC_W-1:0] HI_VEC      = VEC_W'(8),
    parameter logic [VEC_W-1:0] LO_VEC      = VEC_W'(24)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CORE+N_PERIPH-1:0] src_evt_i,
    input  logic [N_CORE+N_PERIPH-1:0] src_en_i,
    input  logic [N_CORE+N_PERIPH-1:0] src_pri_i,
    input  logic                       prio_mode_i,
    input  logic                       glb_we_i,
    input  logic [1:0]                 glb_wdata_i,
    input  logic                       flag_clr_i,
    input  logic [N_CORE+N_PERIPH-1:0] flag_clr_mask_i,
    input  logic                       reti_i,
    output logic                       irq_req_o,
    output logic [VEC_W-1:0]           irq_vec_o,
    output logic [1:0]                 svc_level_o,
    output logic [1:0]                 glb_en_o,
    output logic [N_CORE+N_PERIPH-1:0] flags_o
);

    localparam int unsigned N_SRC = N_CORE + N_PERIPH;

    logic [N_SRC-1:0] flags;
    logic             want_hi, want_lo;
    logic [1:0]       glb_en;

    irq_src_bank #(
        .N_SRC       (N_SRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (src_evt_i),
        .clr_i      (flag_clr_i),
        .clr_mask_i (flag_clr_mask_i),
        .flag_o     (flags)
    );

    irq_qualify #(
        .N_CORE   (N_CORE),
        .N_PERIPH (N_PERIPH)
    ) u_qual (
        .flag_i      (flags),
        .en_i        (src_en_i),
        .pri_i       (src_pri_i),
        .prio_mode_i (prio_mode_i),
        .glb_hi_i    (glb_en[1]),
        .glb_lo_i    (glb_en[0]),
        .want_hi_o   (want_hi),
        .want_lo_o   (want_lo)
    );

    irq_level_fsm #(
        .VEC_W  (VEC_W),
        .HI_VEC (HI_VEC),
        .LO_VEC (LO_VEC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .prio_mode_i (prio_mode_i),
        .want_hi_i   (want_hi),
        .want_lo_i   (want_lo),
        .reti_i      (reti_i),
        .glb_we_i    (glb_we_i),
        .glb_wdata_i (glb_wdata_i),
        .req_o       (irq_req_o),
        .vec_o       (irq_vec_o),
        .level_o     (svc_level_o),
        .glb_en_o    (glb_en)
    );

    assign glb_en_o = glb_en;
    assign flags_o  = flags;

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int unsigned      VEC_W  = 16,
    parameter logic [VEC_W-1:0] HI_VEC = VEC_W'(8),
    parameter logic [VEC_W-1:0] LO_VEC = VEC_W'(24)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prio_mode_i,
    input logic             reti_i,
    input logic             irq_req_o,
    input logic [VEC_W-1:0] irq_vec_o,
    input logic [1:0]       svc_level_o,
    input logic [1:0]       glb_en_o
);

    AST_COMPAT_ONE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !$past(prio_mode_i)) |-> irq_vec_o == HI_VEC); // R3

    AST_TAKE_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> $past(glb_en_o[1])); // R5

    AST_HI_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && irq_vec_o == HI_VEC) |-> (!glb_en_o[1] && svc_level_o == 2'd2)); // R7

    AST_LO_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && irq_vec_o == LO_VEC) |-> (!glb_en_o[0] && svc_level_o == 2'd1)); // R7

    AST_NO_LOW_UNDER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_level_o == 2'd2) |=> !(irq_req_o && irq_vec_o == LO_VEC)); // R8

    AST_RET_LOW_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && svc_level_o == 2'd1) |=> glb_en_o[0]); // R9

    AST_RET_HIGH_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && svc_level_o == 2'd2) |=> glb_en_o[1]); // R9

    AST_NO_TAKE_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !irq_req_o); // R9

endmodule

bind irq_ctrl_top irq_ctrl_chk #(
    .VEC_W  (VEC_W),
    .HI_VEC (HI_VEC),
    .LO_VEC (LO_VEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prio_mode_i (prio_mode_i),
    .reti_i      (reti_i),
    .irq_req_o   (irq_req_o),
    .irq_vec_o   (irq_vec_o),
    .svc_level_o (svc_level_o),
    .glb_en_o    (glb_en_o)
);

// File: tb/irq_ctrl_top_bench.sv
module irq_ctrl_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_evt = '0, src_en = '0, src_pri = '0, clr_mask = '0;
    logic        prio_mode = 1'b0, glb_we = 1'b0, flag_clr = 1'b0, reti = 1'b0;
    logic [1:0]  glb_wdata = '0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [1:0]  svc_level, glb_en;
    logic [3:0]  flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_ctrl_top u_irq_ctrl_top (
        .clk             (clk),
        .rst_n           (rst_n),
        .src_evt_i       (src_evt),
        .src_en_i        (src_en),
        .src_pri_i       (src_pri),
        .prio_mode_i     (prio_mode),
        .glb_we_i        (glb_we),
        .glb_wdata_i     (glb_wdata),
        .flag_clr_i      (flag_clr),
        .flag_clr_mask_i (clr_mask),
        .reti_i          (reti),
        .irq_req_o       (irq_req),
        .irq_vec_o       (irq_vec),
        .svc_level_o     (svc_level),
        .glb_en_o        (glb_en),
        .flags_o         (flags)
    );

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Raise the given events, wait four edges, then drop them
    task automatic fire(logic [3:0] m);
        src_evt = m;
        step(4);
        src_evt = '0;
    endtask

    task automatic wr_glb(logic [1:0] v);
        glb_we = 1'b1; glb_wdata = v;
        step(1);
        glb_we = 1'b0;
    endtask

    task automatic clr(logic [3:0] m);
        flag_clr = 1'b1; clr_mask = m;
        step(1);
        flag_clr = 1'b0; clr_mask = '0;
    endtask

    task automatic ret();
        reti = 1'b1;
        step(1);
        reti = 1'b0;
    endtask

    task automatic t_reset();
        check("R12 req",   32'(irq_req), 0);
        check("R12 vec",   32'(irq_vec), 0);
        check("R12 level", 32'(svc_level), 0);
        check("R12 glb",   32'(glb_en), 0);
        check("R12 flags", 32'(flags), 0);
    endtask

    task automatic t_flag_no_enable();
        src_en = '0;
        fire(4'b1010);
        check("R1 flags set without enable", 32'(flags), 32'hA);
        check("R1 no request", 32'(irq_req), 0);
        step(3);
        check("R1 still no request", 32'(irq_req), 0);
        clr(4'b1010);
        check("R2 clear", 32'(flags), 0);
    endtask

    task automatic t_clear_vs_event();
        src_evt[3] = 1'b1;
        step(2);
        flag_clr = 1'b1; clr_mask = 4'b1000;
        step(1);
        flag_clr = 1'b0; clr_mask = '0;
        src_evt = '0;
        check("R2 event wins over clear", 32'(flags), 32'h8);
        clr(4'b1000);
        check("R2 clear after collision", 32'(flags), 0);
    endtask

    task automatic t_compat_core();
        prio_mode = 1'b0; src_en = 4'b0001; src_pri = '0;
        wr_glb(2'b10);
        src_evt = 4'b0001;
        step(3);
        check("R10 not yet after three edges", 32'(irq_req), 0);
        check("R1 flag at third edge", 32'(flags[0]), 1);
        step(1);
        src_evt = '0;
        check("R10 request on fourth edge", 32'(irq_req), 1);
        check("R3 compat vector", 32'(irq_vec), 32'h8);
        check("R4 core needs only global bit", 32'(svc_level), 2);
        check("R7 global bit cleared", 32'(glb_en), 32'h0);
        step(1);
        check("R7 single-cycle pulse", 32'(irq_req), 0);
        clr(4'b0001);
        ret();
        check("R9 compat return level", 32'(svc_level), 0);
        check("R9 compat return enable", 32'(glb_en), 32'h2);
    endtask

    task automatic t_compat_periph();
        prio_mode = 1'b0; src_en = 4'b0100; src_pri = 4'b0000;
        fire(4'b0100);
        check("R4 periph blocked", 32'(irq_req), 0);
        check("R1 periph flag", 32'(flags[2]), 1);
        step(2);
        check("R4 periph still blocked", 32'(irq_req), 0);
        wr_glb(2'b11);
        check("R4 no take on write edge", 32'(irq_req), 0);
        step(1);
        check("R4 periph taken", 32'(irq_req), 1);
        check("R3 priority ignored", 32'(irq_vec), 32'h8);
        check("R7 only global cleared", 32'(glb_en), 32'h1);
        clr(4'b0100);
        ret();
        check("R9 compat enable back", 32'(glb_en), 32'h3);
        wr_glb(2'b00);
    endtask

    task automatic t_preempt();
        prio_mode = 1'b1; src_en = 4'b0011; src_pri = 4'b0001;
        wr_glb(2'b11);
        fire(4'b0010);
        check("R6 low taken", 32'(irq_req), 1);
        check("R6 low vector", 32'(irq_vec), 32'h18);
        check("R7 low level", 32'(svc_level), 1);
        check("R7 low bit cleared", 32'(glb_en), 32'h2);
        clr(4'b0010);
        fire(4'b0001);
        check("R8 preempt taken", 32'(irq_req), 1);
        check("R8 preempt vector", 32'(irq_vec), 32'h8);
        check("R8 preempt level", 32'(svc_level), 2);
        check("R7 both cleared", 32'(glb_en), 32'h0);
        clr(4'b0001);
        ret();
        check("R11 resumes low", 32'(svc_level), 1);
        check("R11 low bit still clear", 32'(glb_en), 32'h2);
        ret();
        check("R9 back to idle", 32'(svc_level), 0);
        check("R9 low bit set", 32'(glb_en), 32'h3);
    endtask

    task automatic t_high_blocks_low();
        fire(4'b0001);
        check("R6 high taken", 32'(irq_vec), 32'h8);
        clr(4'b0001);
        fire(4'b0010);
        check("R8 low blocked under high", 32'(irq_req), 0);
        step(2);
        check("R8 low still blocked", 32'(irq_req), 0);
        ret();
        check("R9 no take in return cycle", 32'(irq_req), 0);
        check("R9 high bit set", 32'(glb_en), 32'h3);
        step(1);
        check("R8 low taken after return", 32'(irq_req), 1);
        check("R6 low vector after return", 32'(irq_vec), 32'h18);
        clr(4'b0010);
        ret();
    endtask

    task automatic t_both_pending();
        fire(4'b0011);
        check("R6 high first", 32'(irq_vec), 32'h8);
        check("R6 high level first", 32'(svc_level), 2);
        clr(4'b0001);
        ret();
        step(1);
        check("R6 low second", 32'(irq_vec), 32'h18);
        check("R6 low level second", 32'(svc_level), 1);
        clr(4'b0010);
        ret();
    endtask

    task automatic t_low_needs_high();
        wr_glb(2'b01);
        fire(4'b0010);
        check("R5 low blocked without high bit", 32'(irq_req), 0);
        wr_glb(2'b11);
        check("R5 no take on write edge", 32'(irq_req), 0);
        step(1);
        check("R5 low taken with both bits", 32'(irq_req), 1);
        check("R5 low vector", 32'(irq_vec), 32'h18);
        clr(4'b0010);
        ret();
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_flag_no_enable();
        t_clear_vs_event();
        t_compat_core();
        t_compat_periph();
        t_preempt();
        t_high_blocks_low();
        t_both_pending();
        t_low_needs_high();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule